// File: doc/BRIEF.md
# Management Serial Interface Slave Decoder

This block sits on the PHY side of the two-wire management bus: a slow clock from the station manager and one bidirectional data line. It runs on a fast system clock, brings both bus wires into that domain through two-flop synchronizers, and recovers the rising and falling edges of the management clock from the synchronized copy. It waits for a run of at least 32 preamble ones and then decodes the frame that follows. That frame has two start bits, an operation code, a PHY address, a register address, a turnaround and 16 data bits.

A read frame aimed at the strapped address returns the word presented on the register-file read port. Any other address reads as all ones. The block drives the data line only during the 16 read-data bits and signals this with a tri-state enable. A write frame for the strapped address produces a single-cycle write strobe after the last data bit, with the captured word and the decoded register address. Each frame, complete or aborted, sends the decoder back to hunting for a new preamble.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset `mdio_oe` and `reg_wr` are 0.
- R2: The decoder arms only after at least `PRE_LEN` (32) consecutive ones are sampled on rising management-clock edges. The first 0 sampled after that is the first start bit. A run of 31 ones is not enough, and the frame that follows is ignored.
- R3: The second start bit must be 1. If it is 0, the frame is abandoned and the decoder goes back to hunting for a preamble, so a following write has no effect.
- R4: After the start bits the decoder shifts in three fields, MSB first: a 2-bit operation code, a 5-bit PHY address and a 5-bit register address. The register address appears on `reg_addr`.
- R5: Operation code binary 10 is a read. The codes 00, 01 and 11 are all treated as writes.
- R6: Read data is 16 bits, sent MSB first. Each bit is updated on a falling management-clock edge, so the master can sample it on the next rising edge.
- R7: `mdio_oe` rises at the end of the 2-bit turnaround of a read frame and falls after the 16th data bit. It stays 0 throughout every write frame.
- R8: A read whose PHY address differs from `PHY_ADDR` returns 16'hFFFF.
- R9: On the 16th rising edge of a write frame to `PHY_ADDR`, exactly one `reg_wr` pulse carries the captured word. A write to any other PHY address produces no pulse.
- R10: After the 16th data bit the decoder hunts for a fresh full preamble, so a frame sent back to back without a preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_in | input | 1 | Management clock from the bus (asynchronous) |
| mdio_in | input | 1 | Data line as seen at the pad (asynchronous) |
| mdio_out | output | 1 | Data value driven during read data |
| mdio_oe | output | 1 | Tri-state enable for `mdio_out` |
| reg_addr | output | 5 | Decoded register address |
| reg_rdata | input | 16 | Read data from the register file for `reg_addr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Captured write data, valid with `reg_wr` |

## Verification
The hardest conditions to reach are the preamble boundary and the state of the decoder between frames. Both sit inside the decoder's hidden hunting counter, so nothing at the ports shows them directly. The bench drives frames whose preamble is exactly 32 bits, and one frame with 31 bits. It also sends a frame with no preamble directly after a completed frame, and a frame with a bad second start bit. In each of these cases the effect is seen only as a missing write strobe and an unchanged register on a later read. Sweeping every register address with distinct write values and then reading them all back exercises the bit order in both directions.

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter logic [4:0] PHY_ADDR = 5'd3,
  parameter int         PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc_in,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [4:0]  reg_addr,
  input  logic [15:0] reg_rdata,
  output logic        reg_wr,
  output logic [15:0] reg_wdata
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [2:0] S_HUNT = 3'd0, S_ST2 = 3'd1, S_HDR = 3'd2,
                         S_TA = 3'd3, S_DATA = 3'd4;

  logic [2:0]    mdc_q, dio_q;
  logic [2:0]    st;
  logic [PW-1:0] pre_cnt;
  logic [4:0]    bcnt;
  logic [11:0]   hdr;
  logic [15:0]   dsh;

  wire mdc_s = mdc_q[1];
  wire dio_s = dio_q[1];
  wire rise  = mdc_q[1] & ~mdc_q[2];
  wire fall  = ~mdc_q[1] & mdc_q[2];
  wire rd    = hdr[11:10] == 2'b10;
  wire match = hdr[9:5] == PHY_ADDR;

  assign reg_addr  = hdr[4:0];
  assign reg_wdata = dsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= '0; dio_q <= '1;
    end else begin
      mdc_q <= {mdc_q[1:0], mdc_in};
      dio_q <= {dio_q[1:0], mdio_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; pre_cnt <= '0; bcnt <= '0; hdr <= '0; dsh <= '0;
      mdio_out <= 1'b0; mdio_oe <= 1'b0; reg_wr <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      if (fall && st == S_DATA && rd) begin
        mdio_out <= dsh[15];
        dsh      <= {dsh[14:0], 1'b0};
      end
      if (rise) begin
        case (st)
          S_HUNT:
            if (dio_s) begin
              if (pre_cnt != PW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
            end else if (pre_cnt == PW'(PRE_LEN)) st <= S_ST2;
            else pre_cnt <= '0;
          S_ST2: begin
            pre_cnt <= '0;
            bcnt    <= '0;
            st      <= dio_s ? S_HDR : S_HUNT;
          end
          S_HDR: begin
            hdr  <= {hdr[10:0], dio_s};
            bcnt <= bcnt + 1'b1;
            if (bcnt == 5'd11) begin bcnt <= '0; st <= S_TA; end
          end
          S_TA: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == 5'd1) begin
              bcnt <= '0;
              st   <= S_DATA;
              if (rd) begin
                mdio_oe <= 1'b1;
                dsh     <= match ? reg_rdata : 16'hFFFF;
              end else dsh <= '0;
            end
          end
          S_DATA: begin
            if (!rd) dsh <= {dsh[14:0], dio_s};
            bcnt <= bcnt + 1'b1;
            if (bcnt == 5'd15) begin
              bcnt    <= '0;
              st      <= S_HUNT;
              mdio_oe <= 1'b0;
              reg_wr  <= !rd && match;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  wire unused_ok = mdc_s;
endmodule

module mgmt_serial_slave_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic [11:0] hdr,
  input logic        fall,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        reg_wr
);
  p_rst_quiet_r1: assert property (@(posedge clk) $fell(rst_n) |=> (!mdio_oe && !reg_wr));
  p_wr_not_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> hdr[11:10] != 2'b10);
  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(mdio_out));
  p_oe_read_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == 3'd4 && hdr[11:10] == 2'b10));
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  p_wr_own_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> hdr[9:5] == PHY_ADDR);
  p_wr_to_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> st == 3'd0);
endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .hdr(hdr), .fall(fall),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_wr(reg_wr)
);

// File: tb/mgmt_serial_slave_bench.sv
module mgmt_serial_slave_bench;
  localparam int H = 6;
  localparam logic [4:0] MY = 5'd3;

  logic clk = 0, rst_n = 0, mdc_in = 0, mdio_in = 1;
  logic mdio_out, mdio_oe, reg_wr;
  logic [4:0] reg_addr;
  logic [15:0] reg_rdata, reg_wdata;
  logic [15:0] rf [32];
  int checks = 0, errors = 0, wr_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mgmt_serial_slave #(.PHY_ADDR(MY), .PRE_LEN(32)) u_mgmt_serial_slave (
    .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata));

  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) if (reg_wr) begin rf[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end

  function automatic logic [15:0] val(input int r);
    return 16'(r * 16'h0841) ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b);
    mdio_in = b;
    repeat (H) @(negedge clk);
    mdc_in = 1;
    repeat (H) @(negedge clk);
    mdc_in = 0;
  endtask

  task automatic frame(input int pre, input logic st2, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rdv, output bit oe_all, output bit oe_any);
    oe_all = 1; oe_any = 0; rdv = '0;
    for (int i = 0; i < pre; i++) bitx(1'b1);
    bitx(1'b0); bitx(st2);
    for (int i = 1; i >= 0; i--) bitx(op[i]);
    for (int i = 4; i >= 0; i--) bitx(pa[i]);
    for (int i = 4; i >= 0; i--) bitx(ra[i]);
    if (mdio_oe) oe_any = 1;
    bitx(1'b1); bitx(op == 2'b10 ? 1'b1 : 1'b0);
    for (int k = 15; k >= 0; k--) begin
      mdio_in = (op == 2'b10) ? 1'b1 : wd[k];
      repeat (H) @(negedge clk);
      rdv[k] = mdio_out;
      oe_all &= mdio_oe;
      oe_any |= mdio_oe;
      mdc_in = 1;
      repeat (H) @(negedge clk);
      mdc_in = 0;
    end
    mdio_in = 1;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rdv;
    bit oa, on;
    int w0;
    for (int i = 0; i < 32; i++) rf[i] = 16'h0;
    repeat (4) @(negedge clk);
    check("R1 oe", {31'b0, mdio_oe}, 0);
    check("R1 wr", {31'b0, reg_wr}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 oe after release", {31'b0, mdio_oe}, 0);

    // R9 / R4: write every register with exactly 32 preamble bits (R2 lower bound)
    for (int r = 0; r < 32; r++) begin
      w0 = wr_cnt;
      frame(32, 1'b1, 2'b01, MY, 5'(r), val(r), rdv, oa, on);
      check($sformatf("R9 write strobe count reg %0d", r), wr_cnt - w0, 1);
      check("R7 oe low in write", {31'b0, on}, 0);
    end
    // R6 / R4 / R7: read every register
    for (int r = 0; r < 32; r++) begin
      frame(32, 1'b1, 2'b10, MY, 5'(r), 16'h0, rdv, oa, on);
      check($sformatf("R6 read data reg %0d", r), rdv, val(r));
      check("R7 oe during read data", {31'b0, oa}, 1);
      check("R7 oe released", {31'b0, mdio_oe}, 0);
    end
    // R5: opcodes 00 and 11 write
    frame(32, 1'b1, 2'b00, MY, 5'd5, 16'h1357, rdv, oa, on);
    frame(32, 1'b1, 2'b11, MY, 5'd6, 16'h8642, rdv, oa, on);
    frame(32, 1'b1, 2'b10, MY, 5'd5, 16'h0, rdv, oa, on);
    check("R5 op 00 writes", rdv, 16'h1357);
    frame(32, 1'b1, 2'b10, MY, 5'd6, 16'h0, rdv, oa, on);
    check("R5 op 11 writes", rdv, 16'h8642);
    // R8: absent PHY read
    frame(32, 1'b1, 2'b10, 5'd4, 5'd0, 16'h0, rdv, oa, on);
    check("R8 absent phy reads ones", rdv, 16'hFFFF);
    // R9: absent PHY write ignored
    w0 = wr_cnt;
    frame(32, 1'b1, 2'b01, 5'd4, 5'd7, 16'h1234, rdv, oa, on);
    check("R9 absent phy no strobe", wr_cnt - w0, 0);
    frame(32, 1'b1, 2'b10, MY, 5'd7, 16'h0, rdv, oa, on);
    check("R9 reg unchanged after absent write", rdv, val(7));
    // R2: short preamble
    w0 = wr_cnt;
    frame(31, 1'b1, 2'b01, MY, 5'd8, 16'h0F0F, rdv, oa, on);
    check("R2 short preamble no strobe", wr_cnt - w0, 0);
    frame(32, 1'b1, 2'b10, MY, 5'd8, 16'h0, rdv, oa, on);
    check("R2 reg unchanged", rdv, val(8));
    // R3: bad second start bit
    w0 = wr_cnt;
    frame(32, 1'b0, 2'b01, MY, 5'd9, 16'h0F0F, rdv, oa, on);
    check("R3 abort no strobe", wr_cnt - w0, 0);
    frame(32, 1'b1, 2'b10, MY, 5'd9, 16'h0, rdv, oa, on);
    check("R3 reg unchanged", rdv, val(9));
    // R10: back-to-back frame without preamble
    frame(32, 1'b1, 2'b01, MY, 5'd10, 16'hBEEF, rdv, oa, on);
    w0 = wr_cnt;
    frame(0, 1'b1, 2'b01, MY, 5'd10, 16'h0000, rdv, oa, on);
    check("R10 no strobe without preamble", wr_cnt - w0, 0);
    frame(32, 1'b1, 2'b10, MY, 5'd10, 16'h0, rdv, oa, on);
    check("R10 reg keeps first write", rdv, 16'hBEEF);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule